// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the running time of day for a packet time-stamping unit as a seconds word and a sub-second word. On every clock, or only when a frequency-trimming accumulator carries out, the sub-second word grows by a programmable increment. When it passes its modulus it wraps and the seconds word steps. The modulus is either 10^9 (decimal nanoseconds) or 2^31 (binary fractions of about 0.466 ns).

Software drives the block through a small register port. It writes staging values, then sets a command bit that applies them on the next clock and clears itself. The three commands are: load an absolute time, activate a new addend, and add or subtract a signed offset. For subtraction, software encodes the seconds operand as 2^32 minus the amount and the sub-second operand as the modulus minus the amount. The block then resolves the borrow across the rollover. Reading the seconds register takes a snapshot of the sub-second value, so a seconds read followed by a sub-second read always forms one instant. The current time is also driven on two output ports for stamping logic.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, both time words are zero, every control bit reads zero, and the control register (address 0) reads 0.
- R2: In coarse mode (control bit 0 clear), the sub-second word grows by the increment register (address 1) on every clock that carries no pending load or offset.
- R3: In fine mode (control bit 0 set), a 32-bit accumulator adds the active addend every clock, and the time advances by the increment only on a carry out. An addend of 2^31 advances once every two clocks, 2^30 once every four, and 0 never.
- R4: With control bit 1 set (decimal), the sub-second word wraps past 999,999,999. In the same clock the seconds word increments and the remainder carries over.
- R5: With control bit 1 clear (binary), the sub-second word wraps at 2^31 and the seconds word increments in the same clock.
- R6: Writing control bit 2 sets a pending load. In the next clock, seconds and sub-seconds take the staged values (addresses 3 and 4 [30:0]) with no increment, and the bit reads 1 during the pending clock and 0 after it.
- R7: Writing control bit 4 copies the staged addend (address 2) into the active addend (readable at address 7) one clock later, and the bit clears itself.
- R8: Writing control bit 3 with bit 31 of address 4 clear adds the staged seconds and sub-seconds to the time in the next clock, with carry across the rollover and no increment that clock.
- R9: With bit 31 of address 4 set, the offset is a subtraction: the operands are 2^32 minus the seconds amount and the modulus minus the sub-second amount. The block takes one second less when the sub-second sum does not wrap.
- R10: Writing a command bit while that same command is pending has no effect: the command is applied once.
- R11: Reading address 5 returns the seconds and captures the sub-second value at that clock. A later read of address 6 returns the captured value. Read data appears one clock after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Read data, valid one clock after rd_en |
| sec_o | output | DATA_W | Current seconds |
| ns_o | output | DATA_W-1 | Current sub-seconds |

## Verification
The bench builds the block with its defaults: 32-bit words, a 32-bit accumulator, an 8-bit increment and a decimal modulus of 10^9. At these values a load near either modulus puts both wrap points within a few clocks. An addend of 2^31 or 2^30 yields exact, countable advance patterns. Freezing time with a zero increment lets the add, borrow and no-borrow offset cases be checked against exact seconds and nanoseconds.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_INC     = 3'd1,
        REG_ADD_STG = 3'd2,
        REG_SEC_STG = 3'd3,
        REG_NS_STG  = 3'd4,
        REG_SEC_RD  = 3'd5,
        REG_NS_RD   = 3'd6,
        REG_ADD_ACT = 3'd7
    } reg_addr_e;

    localparam int CB_FINE = 0;
    localparam int CB_DEC  = 1;
    localparam int CB_INIT = 2;
    localparam int CB_UPD  = 3;
    localparam int CB_ADD  = 4;

    // packed so that bit 0 is fine, bit 4 is addend pending
    typedef struct packed {
        logic p_add;
        logic p_upd;
        logic p_init;
        logic dec;
        logic fine;
    } ctrl_t;
endpackage

// File: rtl/ptp_tc_rolladd.sv
// Sub-second adder with wrap at a selectable modulus.
module ptp_tc_rolladd #(
    parameter int W = 31
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W:0]   modulus,
    output logic [W-1:0] sum,
    output logic         wrap
);
    logic [W:0] raw;
    logic [W:0] reduced;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b};
        reduced = raw - modulus;
        wrap    = (raw >= modulus);
        sum     = wrap ? reduced[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/ptp_tc_accum.sv
// Frequency-trim accumulator: decides whether the time advances this clock.
module ptp_tc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             fine,
    input  logic [ACC_W-1:0] acc_q,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_d,
    output logic             advance
);
    logic [ACC_W:0] total;

    always_comb begin
        total = {1'b0, acc_q} + {1'b0, addend};
        if (fine) begin
            acc_d   = total[ACC_W-1:0];
            advance = total[ACC_W];
        end else begin
            acc_d   = acc_q;
            advance = 1'b1;
        end
    end
endmodule

// File: rtl/ptp_tc_regs.sv
// Control, staging and active-addend registers with self-clearing commands.
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 32,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [INC_W-1:0]  inc,
    output logic [ACC_W-1:0]  add_stg,
    output logic [ACC_W-1:0]  add_act,
    output logic [DATA_W-1:0] sec_stg,
    output logic [DATA_W-1:0] ns_stg
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [INC_W-1:0]  inc;
        logic [ACC_W-1:0]  add_stg;
        logic [ACC_W-1:0]  add_act;
        logic [DATA_W-1:0] sec_stg;
        logic [DATA_W-1:0] ns_stg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // every pending command executes this clock and clears
        r_d.ctrl.p_init = 1'b0;
        r_d.ctrl.p_upd  = 1'b0;
        r_d.ctrl.p_add  = 1'b0;
        if (r_q.ctrl.p_add) begin
            r_d.add_act = r_q.add_stg;
        end
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    r_d.ctrl.fine   = wr_data[CB_FINE];
                    r_d.ctrl.dec    = wr_data[CB_DEC];
                    r_d.ctrl.p_init = wr_data[CB_INIT] & ~r_q.ctrl.p_init;
                    r_d.ctrl.p_upd  = wr_data[CB_UPD]  & ~r_q.ctrl.p_upd;
                    r_d.ctrl.p_add  = wr_data[CB_ADD]  & ~r_q.ctrl.p_add;
                end
                REG_INC:     r_d.inc     = wr_data[INC_W-1:0];
                REG_ADD_STG: r_d.add_stg = wr_data[ACC_W-1:0];
                REG_SEC_STG: r_d.sec_stg = wr_data;
                REG_NS_STG:  r_d.ns_stg  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl    = r_q.ctrl;
    assign inc     = r_q.inc;
    assign add_stg = r_q.add_stg;
    assign add_act = r_q.add_act;
    assign sec_stg = r_q.sec_stg;
    assign ns_stg  = r_q.ns_stg;
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ACC_W   = 32,
    parameter int          INC_W   = 8,
    parameter int unsigned DEC_MOD = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sec_o,
    output logic [DATA_W-2:0] ns_o
);
    localparam int NS_W = DATA_W - 1;
    localparam logic [NS_W:0] MOD_BIN = {1'b1, {NS_W{1'b0}}};
    localparam logic [NS_W:0] MOD_DEC = (NS_W+1)'(DEC_MOD);

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [NS_W-1:0]   ns;
        logic [ACC_W-1:0]  acc;
        logic [NS_W-1:0]   snap;
        logic [DATA_W-1:0] rd;
    } time_t;

    time_t t_d, t_q;

    ctrl_t             ctrl;
    logic [INC_W-1:0]  inc;
    logic [ACC_W-1:0]  add_stg;
    logic [ACC_W-1:0]  add_act;
    logic [DATA_W-1:0] sec_stg;
    logic [DATA_W-1:0] ns_stg;
    logic [ACC_W-1:0]  acc_next;
    logic              advance;
    logic [NS_W:0]     modulus;
    logic [NS_W-1:0]   tick_sum;
    logic              tick_wrap;
    logic [NS_W-1:0]   off_sum;
    logic              off_wrap;
    logic              off_sub;

    ptp_tc_regs #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .INC_W  (INC_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .inc     (inc),
        .add_stg (add_stg),
        .add_act (add_act),
        .sec_stg (sec_stg),
        .ns_stg  (ns_stg)
    );

    ptp_tc_accum #(
        .ACC_W (ACC_W)
    ) accum_i (
        .fine    (ctrl.fine),
        .acc_q   (t_q.acc),
        .addend  (add_act),
        .acc_d   (acc_next),
        .advance (advance)
    );

    assign modulus = ctrl.dec ? MOD_DEC : MOD_BIN;
    assign off_sub = ns_stg[DATA_W-1];

    ptp_tc_rolladd #(
        .W (NS_W)
    ) tick_add_i (
        .a       (t_q.ns),
        .b       (NS_W'(inc)),
        .modulus (modulus),
        .sum     (tick_sum),
        .wrap    (tick_wrap)
    );

    ptp_tc_rolladd #(
        .W (NS_W)
    ) offset_add_i (
        .a       (t_q.ns),
        .b       (ns_stg[NS_W-1:0]),
        .modulus (modulus),
        .sum     (off_sum),
        .wrap    (off_wrap)
    );

    always_comb begin
        t_d     = t_q;
        t_d.acc = acc_next;
        if (ctrl.p_init) begin
            t_d.sec = sec_stg;
            t_d.ns  = ns_stg[NS_W-1:0];
        end else if (ctrl.p_upd) begin
            // a subtraction borrows unless the sub-second sum wrapped
            t_d.ns  = off_sum;
            t_d.sec = t_q.sec + sec_stg + DATA_W'(off_wrap) - DATA_W'(off_sub);
        end else if (advance) begin
            t_d.ns  = tick_sum;
            t_d.sec = t_q.sec + DATA_W'(tick_wrap);
        end
        if (rd_en) begin
            case (reg_addr_e'(rd_addr))
                REG_CTRL:    t_d.rd = DATA_W'(ctrl);
                REG_INC:     t_d.rd = DATA_W'(inc);
                REG_ADD_STG: t_d.rd = DATA_W'(add_stg);
                REG_SEC_STG: t_d.rd = sec_stg;
                REG_NS_STG:  t_d.rd = ns_stg;
                REG_SEC_RD: begin
                    t_d.rd   = t_q.sec;
                    t_d.snap = t_q.ns;
                end
                REG_NS_RD:   t_d.rd = DATA_W'(t_q.snap);
                REG_ADD_ACT: t_d.rd = DATA_W'(add_act);
                default:     t_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sec_o   = t_q.sec;
    assign ns_o    = t_q.ns;
    assign rd_data = t_q.rd;
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
    parameter int          DATA_W  = 32,
    parameter int          ACC_W   = 32,
    parameter int          INC_W   = 8,
    parameter int unsigned DEC_MOD = 1_000_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] sec,
    input logic [DATA_W-2:0] ns,
    input logic              fine,
    input logic              dec,
    input logic              p_init,
    input logic              p_upd,
    input logic              p_add,
    input logic [INC_W-1:0]  inc,
    input logic [ACC_W-1:0]  addend
);
    localparam logic [DATA_W-2:0] DEC_LIM = (DATA_W-1)'(DEC_MOD);

    // R6: a pending load lasts exactly one clock
    assert_init_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_init |=> !p_init);

    // R7: a pending addend copy lasts exactly one clock
    assert_addend_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        p_add |=> !p_add);

    // R10: a repeated offset write during the pending clock is not re-armed
    assert_update_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        p_upd |=> !p_upd);

    // R4: seconds only step by one, together with a sub-second wrap
    assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(p_init) && !$past(p_upd) && sec != $past(sec))
        |-> (sec == $past(sec) + 1'b1 && ns < $past(ns)));

    // R4: in decimal mode the sub-second word stays below the modulus
    assert_dec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec) && !$past(p_init) && !$past(p_upd) && $past(ns) < DEC_LIM)
        |-> ns < DEC_LIM);

    // R3: a zero addend in fine mode freezes the time
    assert_fine_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fine) && $past(addend) == '0 && !$past(p_init) && !$past(p_upd))
        |-> ($stable(sec) && $stable(ns)));

    // R2: coarse mode with a non-zero increment always moves the sub-seconds
    assert_coarse_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fine) && $past(inc) != '0 && !$past(p_init) && !$past(p_upd))
        |-> !$stable(ns));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(
    .DATA_W  (DATA_W),
    .ACC_W   (ACC_W),
    .INC_W   (INC_W),
    .DEC_MOD (DEC_MOD)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sec    (sec_o),
    .ns     (ns_o),
    .fine   (ctrl.fine),
    .dec    (ctrl.dec),
    .p_init (ctrl.p_init),
    .p_upd  (ctrl.p_upd),
    .p_add  (ctrl.p_add),
    .inc    (inc),
    .addend (add_act)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] sec_o;
    logic [30:0] ns_o;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ptp_time_counter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_o(sec_o), .ns_o(ns_o)
    );

    // behavioural reference model
    longint m_sec, m_ns, m_acc, m_add, m_add_st, m_sec_st, m_ns_st, m_inc, m_snap, m_rd;
    bit     m_fine, m_dec, m_pi, m_pu, m_pa;
    localparam longint TWO32 = 64'd4294967296;
    localparam longint M32   = 64'hFFFF_FFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_ns = 0; m_acc = 0; m_add = 0; m_add_st = 0; m_sec_st = 0;
            m_ns_st = 0; m_inc = 0; m_snap = 0; m_rd = 0;
            m_fine = 0; m_dec = 0; m_pi = 0; m_pu = 0; m_pa = 0;
        end else begin
            longint t, v, modv;
            bit adv, o_pi, o_pu, o_pa, c, sub;
            o_pi = m_pi; o_pu = m_pu; o_pa = m_pa;
            if (rd_en) begin
                case (rd_addr)
                    3'd0: m_rd = longint'(m_fine) | (longint'(m_dec) << 1) | (longint'(o_pi) << 2)
                                 | (longint'(o_pu) << 3) | (longint'(o_pa) << 4);
                    3'd1: m_rd = m_inc;
                    3'd2: m_rd = m_add_st;
                    3'd3: m_rd = m_sec_st;
                    3'd4: m_rd = m_ns_st;
                    3'd5: begin m_rd = m_sec; m_snap = m_ns; end
                    3'd6: m_rd = m_snap;
                    default: m_rd = m_add;
                endcase
            end
            adv = 1;
            if (m_fine) begin
                t = m_acc + m_add;
                adv = (t >= TWO32);
                m_acc = t & M32;
            end
            modv = m_dec ? 64'd1000000000 : 64'd2147483648;
            if (o_pi) begin
                m_sec = m_sec_st;
                m_ns  = m_ns_st & 64'h7FFF_FFFF;
            end else if (o_pu) begin
                sub = m_ns_st[31];
                v = m_ns + (m_ns_st & 64'h7FFF_FFFF);
                c = (v >= modv);
                if (c) v = v - modv;
                m_ns  = v;
                m_sec = (m_sec + m_sec_st + longint'(c) - longint'(sub)) & M32;
            end else if (adv) begin
                v = m_ns + m_inc;
                if (v >= modv) begin
                    v = v - modv;
                    m_sec = (m_sec + 1) & M32;
                end
                m_ns = v;
            end
            if (o_pa) m_add = m_add_st;
            m_pi = 0; m_pu = 0; m_pa = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_fine = wr_data[0];
                        m_dec  = wr_data[1];
                        m_pi   = wr_data[2] && !o_pi;
                        m_pu   = wr_data[3] && !o_pu;
                        m_pa   = wr_data[4] && !o_pa;
                    end
                    3'd1: m_inc    = longint'(wr_data[7:0]);
                    3'd2: m_add_st = longint'(wr_data);
                    3'd3: m_sec_st = longint'(wr_data);
                    3'd4: m_ns_st  = longint'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (sec_o !== m_sec[31:0] || ns_o !== m_ns[30:0] || rd_data !== m_rd[31:0]) begin
                fails++;
                $display("FAIL %s model compare: sec=%0d ns=%0d rd=%h expected sec=%0d ns=%0d rd=%h",
                         cur_req, sec_o, ns_o, rd_data, m_sec, m_ns, m_rd[31:0]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL %s watchdog: cycles=%0d expected below 100000", cur_req, cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint ns0, sec0, exp_sec, exp_ns;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1", sec_o, 0);
        chk("R1", ns_o, 0);
        rd(3'd0);
        chk("R1", rd_data, 0);

        // R2: coarse stepping
        cur_req = "R2";
        wr(3'd1, 32'd10);
        ns0 = ns_o;
        idle(5);
        chk("R2", ns_o, ns0 + 50);

        // R5: binary wrap at 2^31
        cur_req = "R5";
        wr(3'd3, 32'd5);
        wr(3'd4, 32'h7FFF_FFE7);
        wr(3'd0, 32'h4);
        idle(4);
        chk("R5", sec_o, 6);
        chk("R5", ns_o, 5);

        // R6: load, pending bit visible then cleared
        cur_req = "R6";
        wr(3'd0, 32'h4);
        rd(3'd0);
        chk("R6", rd_data, 32'h4);
        chk("R6", sec_o, 5);
        chk("R6", ns_o, 64'h7FFF_FFE7);
        rd(3'd0);
        chk("R6", rd_data, 0);

        // R4: decimal wrap at 10^9
        cur_req = "R4";
        wr(3'd3, 32'd7);
        wr(3'd4, 32'd999_999_985);
        wr(3'd0, 32'h6);
        idle(3);
        chk("R4", sec_o, 8);
        chk("R4", ns_o, 5);

        // R3 / R7: fine mode with addend 2^31
        cur_req = "R7";
        wr(3'd2, 32'h8000_0000);
        wr(3'd0, 32'h13);
        wr(3'd1, 32'd20);
        rd(3'd7);
        chk("R7", rd_data, 64'h8000_0000);
        rd(3'd0);
        chk("R7", rd_data & 32'h10, 0);
        cur_req = "R3";
        idle(1);
        ns0 = ns_o;
        idle(10);
        chk("R3", ns_o, ns0 + 100);
        wr(3'd2, 32'h4000_0000);
        wr(3'd0, 32'h13);
        idle(2);
        ns0 = ns_o;
        idle(16);
        chk("R3", ns_o, ns0 + 80);
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h13);
        idle(2);
        ns0 = ns_o; sec0 = sec_o;
        idle(10);
        chk("R3", ns_o, ns0);
        chk("R3", sec_o, sec0);

        // R8: offset add with time frozen
        cur_req = "R8";
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h2);
        wr(3'd3, 32'd100);
        wr(3'd4, 32'd500_000_000);
        wr(3'd0, 32'h6);
        idle(1);
        chk("R6", sec_o, 100);
        chk("R6", ns_o, 500_000_000);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd600_000_000);
        wr(3'd0, 32'hA);
        idle(1);
        chk("R8", sec_o, 104);
        chk("R8", ns_o, 100_000_000);

        // R9: subtraction without and with sub-second wrap
        cur_req = "R9";
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'h8000_0000 | 32'd800_000_000);
        wr(3'd0, 32'hA);
        idle(1);
        chk("R9", sec_o, 102);
        chk("R9", ns_o, 900_000_000);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd4, 32'h8000_0000 | 32'd600_000_000);
        wr(3'd0, 32'hA);
        idle(1);
        chk("R9", sec_o, 100);
        chk("R9", ns_o, 500_000_000);

        // R10: repeated command while pending applies once
        cur_req = "R10";
        wr(3'd3, 32'd1);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'hA);
        wr(3'd0, 32'hA);
        idle(2);
        chk("R10", sec_o, 101);
        chk("R10", ns_o, 500_000_000);

        // R11: coherent seconds/sub-seconds read pair
        cur_req = "R11";
        wr(3'd1, 32'd10);
        idle(3);
        exp_sec = sec_o; exp_ns = ns_o;
        rd(3'd5);
        chk("R11", rd_data, exp_sec);
        idle(5);
        rd(3'd6);
        chk("R11", rd_data, exp_ns);

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule